// File: doc/BRIEF.md
# Rank-aware FR-FCFS request picker

This block chooses which queued DRAM request should be issued next. It looks at a small read or write queue. Each slot carries a valid bit, the target rank, bank and row. The queue position stands for age: slot 0 is the oldest. The block also reads the row currently open in every bank and a per-rank flag that says whether the rank is free of refresh. Selection is first-ready first-come-first-served: a request that hits the open row of its bank wins over a miss, and ties go to the oldest slot.

A rank that is busy refreshing makes all of its requests invisible to the picker, so traffic to other ranks keeps flowing. When no request targets a usable rank, the block says so explicitly. A direction-switch input drops row-hit preference so that the oldest eligible request goes first right after a read/write turnaround. The whole choice is combinational and settles within the cycle in which its inputs are presented.

Top module: `fr_fcfs_rank_picker`

## Requirements
- R1: A slot whose valid bit is 0 is never selected, whatever its rank, bank and row.
- R2: A slot whose target rank has its availability bit (bit index = rank number) at 0 is never selected, even when it is a row hit.
- R3: With the direction-switch input low, a row hit is selected in preference to any older miss. A row hit is an eligible slot whose bank-state entry rank*NUM_BANKS+bank is marked open with a row equal to the slot's row.
- R4: Among several eligible row hits, the lowest slot index is selected.
- R5: When no eligible slot is a row hit, the lowest eligible slot index is selected.
- R6: With the direction-switch input high, row hits are disregarded and the lowest eligible slot index is selected.
- R7: When no slot is eligible, the valid output is 0 and the index output is 0; otherwise the valid output is 1.
- R8: A matching row in a bank-state entry whose open bit is 0 does not count as a hit.
- R9: Open-row state is matched per rank and bank, so the same bank number on another rank does not produce a hit.
- R10: The outputs follow the inputs within the same cycle; no clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used only to sample the built-in checks |
| rst_ni | input | 1 | Active-low asynchronous reset that gates the built-in checks |
| ent_valid_i | input | DEPTH | Slot occupied flags, bit i = slot i |
| ent_rank_i | input | DEPTH*RANK_W | Target rank per slot, slot i at bits i*RANK_W |
| ent_bank_i | input | DEPTH*BANK_W | Target bank per slot |
| ent_row_i | input | DEPTH*ROW_W | Target row per slot |
| open_valid_i | input | NUM_RANKS*NUM_BANKS | Bank has a row open, entry rank*NUM_BANKS+bank |
| open_row_i | input | NUM_RANKS*NUM_BANKS*ROW_W | Open row per bank-state entry |
| rank_avail_i | input | NUM_RANKS | Rank is not refreshing, bit = rank number |
| dir_switch_i | input | 1 | Bus direction has just turned around |
| pick_idx_o | output | IDX_W | Selected slot index |
| pick_valid_o | output | 1 | An eligible slot was found |

## Verification
Rank exclusion and row-hit preference can fall on the same slot. This happens when the only row hit in the queue targets a refreshing rank. The bench provokes it by opening a row on rank 1, placing a hit to that row ahead of a plain miss to rank 0, and then clearing rank 1's availability. The pick is correct only if the miss is chosen. The bench also places a direction switch alongside a live hit and expects the older miss; with no switch, the hit must win.

// File: rtl/picker_pkg.sv
package picker_pkg;
  function automatic int unsigned sel_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pick_prio_find.sv
module pick_prio_find #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 4
) (
  input  logic [N-1:0] req_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/pick_slot_eval.sv
module pick_slot_eval
  import picker_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned NUM_RANKS = 2,
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROW_W     = 14
) (
  input  logic [DEPTH-1:0]                          ent_valid_i,
  input  logic [DEPTH*sel_w(NUM_RANKS)-1:0]         ent_rank_i,
  input  logic [DEPTH*sel_w(NUM_BANKS)-1:0]         ent_bank_i,
  input  logic [DEPTH*ROW_W-1:0]                    ent_row_i,
  input  logic [NUM_RANKS*NUM_BANKS-1:0]            open_valid_i,
  input  logic [NUM_RANKS*NUM_BANKS*ROW_W-1:0]      open_row_i,
  input  logic [NUM_RANKS-1:0]                      rank_avail_i,
  output logic [DEPTH-1:0]                          elig_o,
  output logic [DEPTH-1:0]                          hit_o
);
  localparam int unsigned RANK_W = sel_w(NUM_RANKS);
  localparam int unsigned BANK_W = sel_w(NUM_BANKS);
  localparam int unsigned SLOT_W = sel_w(NUM_RANKS * NUM_BANKS);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [RANK_W-1:0] rk;
    logic [BANK_W-1:0] bk;
    logic [ROW_W-1:0]  rw;
    logic [SLOT_W-1:0] st;
    logic [ROW_W-1:0]  cur_row;
    assign rk = ent_rank_i[g*RANK_W +: RANK_W];
    assign bk = ent_bank_i[g*BANK_W +: BANK_W];
    assign rw = ent_row_i[g*ROW_W +: ROW_W];
    // bank-state entry = rank*NUM_BANKS + bank
    assign st = SLOT_W'(rk) * SLOT_W'(NUM_BANKS) + SLOT_W'(bk);
    assign cur_row = open_row_i[st*ROW_W +: ROW_W];
    assign elig_o[g] = ent_valid_i[g] & rank_avail_i[rk];
    assign hit_o[g]  = elig_o[g] & open_valid_i[st] & (cur_row == rw);
  end
endmodule

// File: rtl/pick_order_sel.sv
module pick_order_sel #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [DEPTH-1:0] elig_i,
  input  logic [DEPTH-1:0] hit_i,
  input  logic             dir_switch_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  logic [IDX_W-1:0] hit_idx, old_idx;
  logic             hit_any, elig_any;
  logic             use_hit;

  pick_prio_find #(.N(DEPTH), .W(IDX_W)) u_hit_find (
    .req_i(hit_i), .idx_o(hit_idx), .any_o(hit_any)
  );
  pick_prio_find #(.N(DEPTH), .W(IDX_W)) u_old_find (
    .req_i(elig_i), .idx_o(old_idx), .any_o(elig_any)
  );

  // turnaround drops hit preference
  assign use_hit = hit_any & ~dir_switch_i;
  assign idx_o   = use_hit ? hit_idx : old_idx;
  assign valid_o = elig_any;
endmodule

// File: rtl/fr_fcfs_rank_picker.sv
module fr_fcfs_rank_picker
  import picker_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned NUM_RANKS = 2,
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROW_W     = 14,
  localparam int unsigned RANK_W   = sel_w(NUM_RANKS),
  localparam int unsigned BANK_W   = sel_w(NUM_BANKS),
  localparam int unsigned IDX_W    = sel_w(DEPTH)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [DEPTH-1:0]                     ent_valid_i,
  input  logic [DEPTH*RANK_W-1:0]              ent_rank_i,
  input  logic [DEPTH*BANK_W-1:0]              ent_bank_i,
  input  logic [DEPTH*ROW_W-1:0]               ent_row_i,
  input  logic [NUM_RANKS*NUM_BANKS-1:0]       open_valid_i,
  input  logic [NUM_RANKS*NUM_BANKS*ROW_W-1:0] open_row_i,
  input  logic [NUM_RANKS-1:0]                 rank_avail_i,
  input  logic                                 dir_switch_i,
  output logic [IDX_W-1:0]                     pick_idx_o,
  output logic                                 pick_valid_o
);
  logic [DEPTH-1:0] elig, hit;

  pick_slot_eval #(
    .DEPTH(DEPTH), .NUM_RANKS(NUM_RANKS), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)
  ) u_eval (
    .ent_valid_i (ent_valid_i),
    .ent_rank_i  (ent_rank_i),
    .ent_bank_i  (ent_bank_i),
    .ent_row_i   (ent_row_i),
    .open_valid_i(open_valid_i),
    .open_row_i  (open_row_i),
    .rank_avail_i(rank_avail_i),
    .elig_o      (elig),
    .hit_o       (hit)
  );

  pick_order_sel #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_sel (
    .elig_i      (elig),
    .hit_i       (hit),
    .dir_switch_i(dir_switch_i),
    .idx_o       (pick_idx_o),
    .valid_o     (pick_valid_o)
  );

  // slots older than the chosen one
  logic [DEPTH-1:0] older_mask;
  assign older_mask = (DEPTH'(1) << pick_idx_o) - DEPTH'(1);

  a_r1_valid_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_valid_o |-> ent_valid_i[pick_idx_o]);
  a_r2_rank_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_valid_o |-> rank_avail_i[ent_rank_i[pick_idx_o*RANK_W +: RANK_W]]);
  a_r3_hit_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_switch_i && (|hit)) |-> hit[pick_idx_o]);
  a_r4_oldest_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_switch_i && hit[pick_idx_o]) |-> !(|(hit & older_mask)));
  a_r6_switch_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_switch_i && pick_valid_o) |-> !(|(elig & older_mask)));
  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pick_valid_o |-> (pick_idx_o == '0));
endmodule

// File: tb/fr_fcfs_rank_picker_tb_top.sv
module fr_fcfs_rank_picker_tb_top;
  localparam int DEPTH = 16;
  localparam int NR    = 2;
  localparam int NB    = 8;
  localparam int RW    = 14;
  localparam int RKW   = 1;
  localparam int BKW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DEPTH-1:0]       ent_valid;
  logic [DEPTH*RKW-1:0]   ent_rank;
  logic [DEPTH*BKW-1:0]   ent_bank;
  logic [DEPTH*RW-1:0]    ent_row;
  logic [NR*NB-1:0]       open_valid;
  logic [NR*NB*RW-1:0]    open_row;
  logic [NR-1:0]          rank_avail;
  logic                   dir_switch;
  logic [3:0]             pick_idx;
  logic                   pick_valid;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fr_fcfs_rank_picker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ent_valid_i(ent_valid), .ent_rank_i(ent_rank), .ent_bank_i(ent_bank),
    .ent_row_i(ent_row), .open_valid_i(open_valid), .open_row_i(open_row),
    .rank_avail_i(rank_avail), .dir_switch_i(dir_switch),
    .pick_idx_o(pick_idx), .pick_valid_o(pick_valid)
  );

  task automatic clear_all();
    ent_valid = '0; ent_rank = '0; ent_bank = '0; ent_row = '0;
    open_valid = '0; open_row = '0; rank_avail = '1; dir_switch = 1'b0;
  endtask

  task automatic put(input int i, input int r, input int b, input int row);
    ent_valid[i] = 1'b1;
    ent_rank[i*RKW +: RKW] = RKW'(r);
    ent_bank[i*BKW +: BKW] = BKW'(b);
    ent_row[i*RW +: RW]    = RW'(row);
  endtask

  task automatic open_bank(input int r, input int b, input int row);
    open_valid[r*NB+b] = 1'b1;
    open_row[(r*NB+b)*RW +: RW] = RW'(row);
  endtask

  task automatic expect_pick(input string req, input bit ev, input int ei);
    #1;
    checks++;
    if (pick_valid !== ev || pick_idx !== 4'(ei)) begin
      errors++;
      $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
               req, pick_valid, pick_idx, ev, ei);
    end
  endtask

  task automatic t_reset();
    @(negedge clk); clear_all();
    expect_pick("R7 reset empty", 1'b0, 0);
  endtask

  task automatic t_oldest();
    @(negedge clk); clear_all();
    put(9, 0, 1, 3); put(3, 1, 2, 4); put(5, 0, 0, 8);
    expect_pick("R5 oldest miss", 1'b1, 3);
    put(15, 0, 0, 0); ent_valid[3] = 1'b0; ent_valid[5] = 1'b0; ent_valid[9] = 1'b0;
    expect_pick("R5 last slot", 1'b1, 15);
  endtask

  task automatic t_hit_pref();
    @(negedge clk); clear_all();
    open_bank(0, 2, 100);
    put(1, 0, 1, 5); put(6, 0, 2, 100);
    expect_pick("R3 hit over older miss", 1'b1, 6);
  endtask

  task automatic t_multi_hit();
    @(negedge clk); clear_all();
    open_bank(0, 4, 20); open_bank(1, 7, 33);
    put(2, 0, 4, 21); put(11, 1, 7, 33); put(4, 0, 4, 20);
    expect_pick("R4 oldest of hits", 1'b1, 4);
  endtask

  task automatic t_rank_skip();
    @(negedge clk); clear_all();
    put(0, 1, 0, 1); put(2, 0, 0, 1);
    rank_avail = 2'b01;
    expect_pick("R2 skip refreshing rank", 1'b1, 2);
    // same-cycle: only hit sits on the refreshing rank
    @(negedge clk); clear_all();
    open_bank(1, 3, 50);
    put(0, 1, 3, 50); put(5, 0, 3, 51);
    expect_pick("R3 hit on free rank", 1'b1, 0);
    rank_avail = 2'b01;
    expect_pick("R2 hit on refreshing rank dropped", 1'b1, 5);
    @(negedge clk); clear_all();
    put(1, 1, 0, 0); put(7, 1, 5, 9);
    rank_avail = 2'b01;
    expect_pick("R7 all ranks busy", 1'b0, 0);
    rank_avail = 2'b10;
    expect_pick("R10 same-cycle response", 1'b1, 1);
  endtask

  task automatic t_invalid();
    @(negedge clk); clear_all();
    open_bank(0, 0, 7);
    put(0, 0, 0, 7); ent_valid[0] = 1'b0;
    put(8, 0, 1, 2);
    expect_pick("R1 invalid hit ignored", 1'b1, 8);
    ent_valid[8] = 1'b0;
    expect_pick("R1 R7 only invalid slots", 1'b0, 0);
  endtask

  task automatic t_switch();
    @(negedge clk); clear_all();
    open_bank(1, 1, 77);
    put(3, 0, 6, 1); put(7, 1, 1, 77);
    dir_switch = 1'b1;
    expect_pick("R6 switch takes oldest", 1'b1, 3);
    dir_switch = 1'b0;
    expect_pick("R6 no switch takes hit", 1'b1, 7);
  endtask

  task automatic t_closed();
    @(negedge clk); clear_all();
    open_bank(0, 5, 40); open_valid[5] = 1'b0;
    put(2, 1, 0, 9); put(10, 0, 5, 40);
    expect_pick("R8 closed bank no hit", 1'b1, 2);
  endtask

  task automatic t_other_rank();
    @(negedge clk); clear_all();
    open_bank(1, 3, 50);
    put(2, 1, 1, 1); put(6, 0, 3, 50);
    expect_pick("R9 other rank no hit", 1'b1, 2);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_all();
    t_reset();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_oldest();
    t_hit_pref();
    t_multi_hit();
    t_rank_skip();
    t_invalid();
    t_switch();
    t_closed();
    t_other_rank();
    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule